// File: doc/BRIEF.md
# DRAM Forced Refresh Sequencer

This block keeps a dynamic memory refreshed while its controller runs in automatic access mode. A slow refresh period clock marks out windows, and each window must contain exactly one refresh. When the system fits a hidden refresh into the high phase of that clock, nothing else is needed. When it does not, the block pulls an active-low request line toward the bus arbiter as soon as the period clock falls. The arbiter grants the bus by driving an active-low acknowledge. The block then produces a row strobe of fixed length on all four bank outputs together, and it places the 7-bit refresh row counter on the address outputs while the strobe is active.

All sequencing runs on a separate strobe-generator clock. The period clock, the acknowledge and the remaining control inputs are brought into that clock domain through two-flop synchronizers, and every output is registered. If the period clock is held high for a long time, the block switches to an externally controlled mode. In that mode the four row strobes copy an external strobe input while the acknowledge is low, and pulling the request line low from outside clears the row counter. The column strobe stays inactive in every mode.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, `req_n`, all four bits of `ras_n` and `cas_n` are 1, and `addr` is 0.
- R2: When `rfclk` falls after a high phase of fewer than EXT_CYC cycles with no hidden refresh, `req_n` goes to 0 three generator cycles after the falling input is applied, and it is still 1 after two cycles.
- R3: A rising edge on `hid_rfsh` during the high phase of `rfclk` stops the request at the next fall of `rfclk` and advances the row counter by one.
- R4: In normal mode, when `ack_n` goes low, all four `ras_n` bits go to 0 together on the fourth generator cycle. `req_n` returns to 1 on that same cycle.
- R5: A normal-mode strobe lasts exactly STROBE_CYC (2) generator cycles. During the strobe `addr` shows the row counter, and at all other times in normal mode `addr` is 0.
- R6: If `ack_n` returns high two cycles after it fell, the strobe ends early and lasts one cycle instead of two.
- R7: A single low period of `ack_n` yields one strobe only. Holding `ack_n` low after the strobe has ended does not start another.
- R8: The row counter advances by one at the end of each strobe and wraps from 127 to 0.
- R9: After `rfclk` has stayed high for EXT_CYC (64) cycles, the block is in external mode. In this mode `req_n` stays 1, and while `ack_n` is low, `addr` shows the counter and `ras_n` copies `ext_ras_n` on all four bits three cycles later. The counter advances on each rising edge of `ext_ras_n`.
- R10: In external mode, holding `req_pull_n` low clears the row counter to 0.
- R11: `cas_n` stays 1 through every refresh, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Strobe-generator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rfclk | input | 1 | Refresh period clock (asynchronous) |
| ack_n | input | 1 | Active-low refresh acknowledge / strobe from the system |
| hid_rfsh | input | 1 | Hidden refresh indication; a rising edge counts as one refresh |
| ext_ras_n | input | 1 | External row strobe, copied to the banks in external mode |
| req_pull_n | input | 1 | External pull-down on the request line; clears the counter in external mode |
| req_n | output | 1 | Active-low refresh request to the bus arbiter |
| ras_n | output | 4 | Active-low row strobes, one per bank |
| cas_n | output | 1 | Column strobe, held inactive |
| addr | output | 7 | Refresh row address |

## Verification
The hardest state to reach from the ports is external mode. The bench gets there by holding `rfclk` high past the detection window, then drives `ack_n`, `ext_ras_n` and `req_pull_n` in sequence. It also checks that the fall of `rfclk` on leaving this mode raises no request. Counter wrap comes from a sweep of 130 back-to-back forced refreshes. Each one checks latency, strobe length and the expected address, which the bench computes as a count modulo 128.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_STR  = 2'd2,
    ST_DONE = 2'd3
  } rfs_state_e;
endpackage

// File: rtl/rfs_sync2.sv
module rfs_sync2 #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/rfs_period.sv
module rfs_period #(
  parameter int EXT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rfclk_s,
  input  logic hid_rise,
  input  logic str_start,
  output logic req_n,
  output logic ext_mode
);
  localparam int EW = $clog2(EXT_CYC + 1);

  logic          rf_d;
  logic [EW-1:0] hi_cnt, hi_cnt_n;
  logic          served, served_n;
  logic          pend, pend_n;
  logic          ext_n;
  logic          rf_rise, rf_fall;

  always_comb begin
    rf_rise = rfclk_s & ~rf_d;
    rf_fall = ~rfclk_s & rf_d;

    if (!rfclk_s)                       hi_cnt_n = '0;
    else if (hi_cnt == EW'(EXT_CYC))    hi_cnt_n = hi_cnt;
    else                                hi_cnt_n = hi_cnt + 1'b1;
    ext_n = rfclk_s && (hi_cnt_n == EW'(EXT_CYC));

    served_n = served;
    if (rf_rise)  served_n = 1'b0;
    if (hid_rise) served_n = 1'b1;

    pend_n = pend;
    if (rf_fall && !served && !hid_rise && !ext_mode) pend_n = 1'b1;
    if (hid_rise || str_start || ext_n)               pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_d     <= 1'b0;
      hi_cnt   <= '0;
      served   <= 1'b0;
      pend     <= 1'b0;
      ext_mode <= 1'b0;
      req_n    <= 1'b1;
    end else begin
      rf_d     <= rfclk_s;
      hi_cnt   <= hi_cnt_n;
      served   <= served_n;
      pend     <= pend_n;
      ext_mode <= ext_n;
      req_n    <= ~pend_n;
    end
  end
endmodule

// File: rtl/rfs_fsm.sv
module rfs_fsm
  import rfs_pkg::*;
#(
  parameter int STROBE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_s,
  input  logic ext_mode,
  output logic str_start,
  output logic str_end,
  output logic str_next
);
  localparam int SW = $clog2(STROBE_CYC + 1);

  rfs_state_e    state, state_n;
  logic [SW-1:0] scnt, scnt_n;

  always_comb begin
    state_n   = state;
    scnt_n    = scnt;
    str_start = 1'b0;
    str_end   = 1'b0;
    unique case (state)
      ST_IDLE: if (!ack_s && !ext_mode) state_n = ST_ARM;
      ST_ARM: begin
        state_n   = ST_STR;
        scnt_n    = SW'(1);
        str_start = 1'b1;
      end
      ST_STR: begin
        if (ack_s || scnt == SW'(STROBE_CYC)) begin
          state_n = ST_DONE;
          str_end = 1'b1;
        end else begin
          scnt_n = scnt + 1'b1;
        end
      end
      ST_DONE: if (ack_s) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
    str_next = (state_n == ST_STR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      scnt  <= '0;
    end else begin
      state <= state_n;
      scnt  <= scnt_n;
    end
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int ROWS       = 128,
  parameter int NBANK      = 4,
  parameter int STROBE_CYC = 2,
  parameter int EXT_CYC    = 64,
  localparam int RW        = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rfclk,
  input  logic             ack_n,
  input  logic             hid_rfsh,
  input  logic             ext_ras_n,
  input  logic             req_pull_n,
  output logic             req_n,
  output logic [NBANK-1:0] ras_n,
  output logic             cas_n,
  output logic [RW-1:0]    addr
);
  logic [1:0] rst_pipe;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  logic [4:0] raw_in, syn;
  logic rfclk_s, ack_s, hid_s, xras_s, pull_s;

  assign raw_in = {req_pull_n, ext_ras_n, hid_rfsh, ack_n, rfclk};

  rfs_sync2 #(.W(5), .RST_VAL(5'b11010)) u_sync (
    .clk(clk), .rst_n(rst_i), .d(raw_in), .q(syn)
  );
  assign {pull_s, xras_s, hid_s, ack_s, rfclk_s} = syn;

  logic hid_d, xras_d, hid_rise, xras_rise;
  logic str_start, str_end, str_next, ext_mode;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      hid_d  <= 1'b0;
      xras_d <= 1'b1;
    end else begin
      hid_d  <= hid_s;
      xras_d <= xras_s;
    end
  end
  assign hid_rise  = hid_s & ~hid_d;
  assign xras_rise = xras_s & ~xras_d;

  rfs_period #(.EXT_CYC(EXT_CYC)) u_period (
    .clk(clk), .rst_n(rst_i), .rfclk_s(rfclk_s), .hid_rise(hid_rise),
    .str_start(str_start), .req_n(req_n), .ext_mode(ext_mode)
  );

  rfs_fsm #(.STROBE_CYC(STROBE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_i), .ack_s(ack_s), .ext_mode(ext_mode),
    .str_start(str_start), .str_end(str_end), .str_next(str_next)
  );

  logic [RW-1:0]    cnt, cnt_n, addr_n;
  logic [NBANK-1:0] ras_nn;
  logic             adv;

  always_comb begin
    adv = str_end || hid_rise || (ext_mode && !ack_s && xras_rise);
    cnt_n = cnt;
    if (ext_mode && !pull_s)
      cnt_n = '0;
    else if (adv)
      cnt_n = (cnt == RW'(ROWS - 1)) ? '0 : cnt + 1'b1;

    if (ext_mode) begin
      ras_nn = !ack_s ? {NBANK{xras_s}} : '1;
      addr_n = !ack_s ? cnt : '0;
    end else begin
      ras_nn = str_next ? '0 : '1;
      addr_n = str_next ? cnt : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cnt   <= '0;
      ras_n <= '1;
      addr  <= '0;
      cas_n <= 1'b1;
    end else begin
      cnt   <= cnt_n;
      ras_n <= ras_nn;
      addr  <= addr_n;
      cas_n <= 1'b1;
    end
  end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int NBANK      = 4,
  parameter int RW         = 7,
  parameter int STROBE_CYC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_n,
  input logic [NBANK-1:0] ras_n,
  input logic [RW-1:0]    addr,
  input logic [RW-1:0]    cnt,
  input logic             ext_mode
);
  localparam int LW = $clog2(STROBE_CYC + 2) + 1;
  logic [LW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     low_run <= '0;
    else if (!ras_n[0] && !ext_mode) low_run <= (low_run == '1) ? low_run : low_run + 1'b1;
    else                            low_run <= '0;
  end

  AST_BANKS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == '0 || ras_n == '1)); // R4
  AST_REQ_OFF_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !$past(ext_mode) && $fell(ras_n[0])) |-> req_n); // R4
  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= LW'(STROBE_CYC)); // R5
  AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !$past(ext_mode) && ras_n[0]) |-> addr == '0); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !$past(ext_mode) && $rose(ras_n[0])) |-> cnt == RW'($past(cnt) + 1'b1)); // R8
  AST_EXT_REQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> req_n); // R9
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .NBANK(NBANK), .RW(RW), .STROBE_CYC(STROBE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_n(req_n), .ras_n(ras_n),
  .addr(addr), .cnt(cnt), .ext_mode(ext_mode)
);

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;
  logic clk = 1'b0;
  logic rst_n, rfclk, ack_n, hid_rfsh, ext_ras_n, req_pull_n;
  logic req_n, cas_n;
  logic [3:0] ras_n;
  logic [6:0] addr;

  int n_run = 0, n_fail = 0, expc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dram_refresh_seq dut (
    .clk(clk), .rst_n(rst_n), .rfclk(rfclk), .ack_n(ack_n), .hid_rfsh(hid_rfsh),
    .ext_ras_n(ext_ras_n), .req_pull_n(req_pull_n), .req_n(req_n),
    .ras_n(ras_n), .cas_n(cas_n), .addr(addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // forced refresh; returns latency, strobe length, banks, address, request, column strobe
  task automatic do_refresh(input bit early, output int lat, output int len,
                            output int banks, output int adr, output int rq, output int cs);
    ack_n = 1'b0;
    lat = 0;
    while (ras_n == 4'hF && lat < 12) begin
      @(negedge clk); lat++;
      if (early && lat == 2) ack_n = 1'b1;
    end
    banks = ras_n; adr = addr; rq = req_n; cs = cas_n;
    len = 0;
    while (ras_n != 4'hF && len < 12) begin
      @(negedge clk); len++;
    end
    ack_n = 1'b1;
    waitn(5);
  endtask

  initial begin
    int lat, len, banks, adr, rq, cs, extra;
    rst_n = 1'b0; rfclk = 1'b0; ack_n = 1'b1; hid_rfsh = 1'b0;
    ext_ras_n = 1'b1; req_pull_n = 1'b1;
    waitn(3);
    check(req_n && ras_n == 4'hF && cas_n && addr == 0, "R1 in reset", {req_n, ras_n, cas_n}, 'h3F);
    rst_n = 1'b1;
    waitn(6);
    check(req_n && ras_n == 4'hF && cas_n && addr == 0, "R1 after release", {req_n, ras_n, cas_n}, 'h3F);

    // R8 sweep with R4/R5/R11 per strobe
    for (int i = 0; i < 130; i++) begin
      do_refresh(1'b0, lat, len, banks, adr, rq, cs);
      check(lat == 4, "R4 latency", lat, 4);
      check(banks == 0, "R4 all banks", banks, 0);
      check(len == 2, "R5 strobe length", len, 2);
      check(adr == expc % 128, "R8 row address", adr, expc % 128);
      check(cs == 1, "R11 cas_n", cs, 1);
      check(addr == 0, "R5 addr idle", addr, 0);
      expc++;
    end

    // R7: held acknowledge gives one strobe only
    ack_n = 1'b0;
    waitn(6);
    extra = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (ras_n != 4'hF) extra++;
    end
    check(extra == 0, "R7 no retrigger", extra, 0);
    ack_n = 1'b1; waitn(5);
    expc++;

    // R2: request after a missed high phase, R4: request withdrawn with strobe
    rfclk = 1'b1; waitn(10);
    rfclk = 1'b0; waitn(2);
    check(req_n == 1, "R2 req still high", req_n, 1);
    waitn(1);
    check(req_n == 0, "R2 req low", req_n, 0);
    waitn(4);
    check(req_n == 0, "R2 req held", req_n, 0);
    do_refresh(1'b0, lat, len, banks, adr, rq, cs);
    check(rq == 1, "R4 req off at strobe", rq, 1);
    check(adr == expc % 128, "R8 row address", adr, expc % 128);
    expc++;

    // R3: hidden refresh suppresses the request and advances the counter
    rfclk = 1'b1; waitn(3);
    hid_rfsh = 1'b1; waitn(3);
    hid_rfsh = 1'b0; waitn(4);
    rfclk = 1'b0; waitn(8);
    check(req_n == 1, "R3 no request", req_n, 1);
    expc++;
    do_refresh(1'b0, lat, len, banks, adr, rq, cs);
    check(adr == expc % 128, "R3 counter advanced", adr, expc % 128);
    expc++;

    // R6: early release
    do_refresh(1'b1, lat, len, banks, adr, rq, cs);
    check(len == 1, "R6 early end", len, 1);
    check(adr == expc % 128, "R6 address", adr, expc % 128);
    expc++;
    do_refresh(1'b0, lat, len, banks, adr, rq, cs);
    check(adr == expc % 128, "R8 after early end", adr, expc % 128);
    expc++;

    // R9/R10: external mode
    rfclk = 1'b1; waitn(80);
    check(req_n == 1, "R9 req high", req_n, 1);
    ack_n = 1'b0; waitn(6);
    check(addr == expc % 128, "R9 addr", addr, expc % 128);
    check(ras_n == 4'hF, "R9 ras idle", ras_n, 15);
    ext_ras_n = 1'b0; waitn(2);
    check(ras_n == 4'hF, "R9 ras latency", ras_n, 15);
    waitn(1);
    check(ras_n == 4'h0, "R9 ras follows", ras_n, 0);
    check(cas_n == 1, "R11 cas_n ext", cas_n, 1);
    waitn(3);
    ext_ras_n = 1'b1; waitn(3);
    check(ras_n == 4'hF, "R9 ras release", ras_n, 15);
    waitn(3);
    expc++;
    check(addr == expc % 128, "R9 counter advance", addr, expc % 128);
    check(req_n == 1, "R9 req still high", req_n, 1);
    req_pull_n = 1'b0; waitn(5);
    req_pull_n = 1'b1; waitn(3);
    check(addr == 0, "R10 counter cleared", addr, 0);
    expc = 0;
    ack_n = 1'b1; rfclk = 1'b0; waitn(8);
    check(req_n == 1, "R9 no request on exit", req_n, 1);
    do_refresh(1'b0, lat, len, banks, adr, rq, cs);
    check(adr == 0, "R10 address after clear", adr, 0);
    check(len == 2, "R5 normal after exit", len, 2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule